// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked host to an asynchronous static RAM of 128K bytes. The host offers one access at a time on a request/ready handshake: a valid strobe, a read/write flag, a 17-bit address and a write byte. The controller then produces the chip-enable, output-enable and write-enable pins, the address pins and the bidirectional data pins. Each read ends with the captured byte and a single-cycle response pulse.

Every minimum timing figure of the RAM is a parameter in picoseconds. At elaboration each figure is converted to a whole number of clock cycles, rounding up against the clock period parameter. A write is the overlap of chip-enable low and write-enable low. The two strobes fall on the same edge and rise on the same edge, so the rising edge is the reference for data setup. A build-time option keeps output-enable low through writes. In that variant the controller waits for the RAM to release the data bus before driving it, and it lengthens the strobe to cover the wait.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the cycle after it is released, req_ready is 1, rsp_valid is 0 and ram_ce_n, ram_oe_n and ram_we_n are all 1.
- R2: A read holds ram_ce_n and ram_oe_n low with ram_we_n high for exactly RD_CYC cycles, where RD_CYC is the largest of the rounded-up read cycle, address-access, enable-access and output-enable-access times (3 cycles at 200 MHz). The byte on the data pins in the last of those cycles is returned on rsp_rdata with rsp_valid high for exactly one cycle, RD_CYC clock edges after the accepting edge.
- R3: In a write, ram_ce_n and ram_we_n fall on the same edge and rise on the same edge. They stay low for STB_CYC cycles (2 at 200 MHz with output-enable high), and the byte driven in the last strobe cycle is the one stored.
- R4: With the default option (OE_HELD_LOW = 0), ram_oe_n stays 1 throughout a write. The write byte is driven for the whole strobe, which is at least the rounded-up data setup time.
- R5: With OE_HELD_LOW = 1, ram_oe_n is low together with the write strobe. The controller starts driving the data pins only after the rounded-up write-enable-to-high-impedance time has passed since the strobe fell. The strobe lasts at least that time plus the data setup time (4 cycles at 200 MHz).
- R6: The strobe falls of two consecutive writes are at least the rounded-up write cycle time apart (3 cycles at 200 MHz with output-enable high, 5 with it held low).
- R7: The data pins are driven only while ram_ce_n and ram_we_n are both low. After a read ends, the chip stays deselected for at least 2 cycles before a following access starts.
- R8: req_ready is 0 while an access is in progress, and a request presented while req_ready is 0 has no effect.
- R9: ram_addr does not change while a read or a write strobe is active. It changes only on the edge that accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host presents an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle pulse when read data is present |
| rsp_rdata | output | 8 | Byte captured by the last read |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_addr | output | 17 | RAM address pins |
| ram_dq | inout | 8 | RAM data pins |

## Verification
The bound checker checks the following on every cycle:
- the exact lengths of the read window and the write strobe;
- that the two write strobes rise together;
- how long data is driven before the strobe ends, and the release wait before driving when output-enable is held low;
- that the data pins are never driven outside the strobe or in the cycle after a read;
- that the address is stable while the chip is enabled, that ready is low while enabled, and that the response is a single pulse.

Only the bench's scenarios can show the rest:
- that the correct bytes reach the RAM and return;
- the spacing between back-to-back writes;
- the deselected gap between a read and a following write;
- that a request made while busy leaves the stored byte unchanged.

The bench runs both option settings against behavioural RAM models.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Package sram_ctl_pkg
// Shared state encoding and the elaboration-time helpers that turn
// picosecond timing figures into clock-cycle counts.
// Assumes all figures and the clock period are positive integers in ps.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_REST  = 3'd4
    } ctl_state_e;

    // Round a time up to a whole number of clock periods.
    function automatic int ps_to_cyc(input int t_ps, input int per_ps);
        return (t_ps + per_ps - 1) / per_ps;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
// Module sram_ctl_fsm
// Access sequencer: accepts one host request when idle and plays out the
// strobe pattern for a read or a write, cycle by cycle, from the derived
// cycle counts. All pin strobes come straight from flops.
// Assumes RD_CYC >= 1, STB_CYC >= 1, HZ_CYC < STB_CYC, and a counter
// wide enough for the largest count.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC      = 3,
    parameter int STB_CYC     = 2,
    parameter int HZ_CYC      = 0,
    parameter int REST_CYC    = 0,
    parameter int CNT_W       = 2,
    parameter bit OE_HELD_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic load,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drv_en
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LAST   = CNT_W'(imax(HZ_CYC, 1) - 1);
    localparam logic [CNT_W-1:0] REST_LAST = CNT_W'(imax(REST_CYC, 1) - 1);
    localparam bit               HAS_REST  = (REST_CYC > 0);
    localparam bit               HAS_HZ    = (HZ_CYC > 0);

    ctl_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             wr_oe_n;
    logic             ce_q, oe_q, we_q, drv_q;

    // Output-enable level used during writes, chosen by the build option.
    generate
        if (OE_HELD_LOW) begin : g_oe_low
            assign wr_oe_n = 1'b0;
        end else begin : g_oe_high
            assign wr_oe_n = 1'b1;
        end
    endgenerate

    // Handshake and datapath strobes decoded from the current state.
    assign req_ready = (state == ST_IDLE);
    assign load      = (state == ST_IDLE) && req_valid;
    assign capture   = (state == ST_READ) && (cnt == RD_LAST);

    // State, cycle counter and registered pin strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ce_q  <= 1'b1;
            oe_q  <= 1'b1;
            we_q  <= 1'b1;
            drv_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cnt  <= '0;
                        ce_q <= 1'b0;
                        if (req_write) begin
                            we_q  <= 1'b0;
                            oe_q  <= wr_oe_n;
                            drv_q <= !HAS_HZ;
                            state <= ST_WRITE;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt == RD_LAST) begin
                        ce_q  <= 1'b1;
                        oe_q  <= 1'b1;
                        state <= ST_TURN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    state <= ST_IDLE;
                end
                ST_WRITE: begin
                    if (cnt == STB_LAST) begin
                        ce_q  <= 1'b1;
                        we_q  <= 1'b1;
                        oe_q  <= 1'b1;
                        drv_q <= 1'b0;
                        cnt   <= '0;
                        state <= HAS_REST ? ST_REST : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (HAS_HZ && (cnt == HZ_LAST)) begin
                            drv_q <= 1'b1;
                        end
                    end
                end
                ST_REST: begin
                    if (cnt == REST_LAST) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ce_n   = ce_q;
    assign oe_n   = oe_q;
    assign we_n   = we_q;
    assign drv_en = drv_q;

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
// Module sram_ctl_dpath
// Holds the address and write byte of the accepted request for the whole
// access, and captures the read byte with a one-cycle response pulse.
// Assumes load only in the idle state and capture only at the read end.
module sram_ctl_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Latch the request fields on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the read byte and pulse the response for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Module sram_ctl
// Top of the asynchronous SRAM controller. Converts each timing figure to
// cycles, instantiates the sequencer and the datapath, and owns the
// tri-state data pins.
// Assumes the clock period parameter matches the real clock; all figures
// are minimums in picoseconds.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int T_RDCYC_PS    = 12000,
    parameter int T_ADDR_ACC_PS = 12000,
    parameter int T_CE_ACC_PS   = 12000,
    parameter int T_OE_ACC_PS   = 6000,
    parameter int T_WRCYC_PS    = 12000,
    parameter int T_WE_PW_PS    = 8000,
    parameter int T_CE_WEND_PS  = 9000,
    parameter int T_ADDR_WEND_PS= 8000,
    parameter int T_DSETUP_PS   = 6000,
    parameter int T_WE_HIZ_PS   = 6000,
    parameter bit OE_HELD_LOW   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq
);

    localparam int RD_CYC   = imax(1, imax(imax(ps_to_cyc(T_RDCYC_PS, CLK_PERIOD_PS),
                                                ps_to_cyc(T_ADDR_ACC_PS, CLK_PERIOD_PS)),
                                           imax(ps_to_cyc(T_CE_ACC_PS, CLK_PERIOD_PS),
                                                ps_to_cyc(T_OE_ACC_PS, CLK_PERIOD_PS))));
    localparam int SD_CYC   = imax(1, ps_to_cyc(T_DSETUP_PS, CLK_PERIOD_PS));
    localparam int STB_BASE = imax(SD_CYC, imax(ps_to_cyc(T_WE_PW_PS, CLK_PERIOD_PS),
                                                imax(ps_to_cyc(T_CE_WEND_PS, CLK_PERIOD_PS),
                                                     ps_to_cyc(T_ADDR_WEND_PS, CLK_PERIOD_PS))));
    localparam int HZ_CYC   = OE_HELD_LOW ? ps_to_cyc(T_WE_HIZ_PS, CLK_PERIOD_PS) : 0;
    localparam int STB_CYC  = imax(STB_BASE, HZ_CYC + SD_CYC);
    localparam int REST_CYC = imax(0, ps_to_cyc(T_WRCYC_PS, CLK_PERIOD_PS) - STB_CYC - 1);
    localparam int CNT_W    = $clog2(imax(imax(RD_CYC, STB_CYC), REST_CYC) + 1);

    logic              load;
    logic              capture;
    logic              drv_en;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dq_in;

    sram_ctl_fsm #(
        .RD_CYC      (RD_CYC),
        .STB_CYC     (STB_CYC),
        .HZ_CYC      (HZ_CYC),
        .REST_CYC    (REST_CYC),
        .CNT_W       (CNT_W),
        .OE_HELD_LOW (OE_HELD_LOW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .load      (load),
        .capture   (capture),
        .ce_n      (ram_ce_n),
        .oe_n      (ram_oe_n),
        .we_n      (ram_we_n),
        .drv_en    (drv_en)
    );

    sram_ctl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (dq_in),
        .addr_q    (ram_addr),
        .wdata_q   (wdata_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Data pins: driven only in the write-data window, else high impedance.
    assign ram_dq = drv_en ? wdata_q : {DATA_W{1'bz}};
    assign dq_in  = ram_dq;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
// Module sram_ctl_chk
// Protocol checker bound to sram_ctl. Measures strobe, read and drive
// lengths with small counters and checks them at the strobe ends.
// Assumes the cycle counts passed in are those derived by the top.
module sram_ctl_chk #(
    parameter int ADDR_W      = 17,
    parameter int RD_CYC      = 3,
    parameter int STB_CYC     = 2,
    parameter int SD_CYC      = 2,
    parameter int HZ_CYC      = 0,
    parameter bit OE_HELD_LOW = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              drv_en
);

    logic [15:0]       wlen, dlen, rlen;
    logic              prev_read;
    logic              ce_prev;
    logic [ADDR_W-1:0] addr_prev;

    // Run-length counters and one-cycle history of the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlen      <= '0;
            dlen      <= '0;
            rlen      <= '0;
            prev_read <= 1'b0;
            ce_prev   <= 1'b1;
            addr_prev <= '0;
        end else begin
            wlen      <= !ram_we_n ? wlen + 1'b1 : '0;
            dlen      <= drv_en ? dlen + 1'b1 : '0;
            rlen      <= (!ram_ce_n && !ram_oe_n && ram_we_n) ? rlen + 1'b1 : '0;
            prev_read <= !ram_ce_n && !ram_oe_n && ram_we_n;
            ce_prev   <= ram_ce_n;
            addr_prev <= ram_addr;
        end
    end

    // R2: read window length
    p_read_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ram_oe_n) && $past(ram_we_n)) |-> (int'(rlen) == RD_CYC));
    // R2: response is a single-cycle pulse
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R3: write enable low only with chip enable low
    p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_ce_n);
    // R3: both strobes end on the same edge
    p_strobe_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> $rose(ram_ce_n));
    // R3: strobe length
    p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (int'(wlen) == STB_CYC));
    // R4: data setup before the terminating edge
    p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (int'(dlen) >= SD_CYC));
    // R4/R5: output-enable level during a write follows the option
    p_oe_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (ram_oe_n == !OE_HELD_LOW));
    // R5: bus release wait before driving with output-enable low
    p_hiz_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !ram_oe_n) |-> (int'(wlen) >= HZ_CYC));
    // R7: drive only inside the write strobe
    p_drive_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!ram_we_n && !ram_ce_n));
    // R7: no drive in the cycle after a read cycle
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prev_read |-> !drv_en);
    // R8: ready stays low while the chip is enabled
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> !req_ready);
    // R9: address stable while the chip stays enabled
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && !ce_prev) |-> (ram_addr == addr_prev));

endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W      (ADDR_W),
    .RD_CYC      (RD_CYC),
    .STB_CYC     (STB_CYC),
    .SD_CYC      (SD_CYC),
    .HZ_CYC      (HZ_CYC),
    .OE_HELD_LOW (OE_HELD_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_ce_n  (ram_ce_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .ram_addr  (ram_addr),
    .drv_en    (drv_en)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
// Behavioural RAM with pin monitors. Stores on the end of the CE/WE
// overlap; records strobe, read and idle lengths and the period between
// chip-enable falls; counts address and strobe-pairing errors.
module sram_ctl_test_ram (
    input  logic        clk,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [16:0] addr,
    inout  wire  [7:0]  dq,
    output logic [7:0]  last_stb,
    output logic [7:0]  last_rd,
    output logic [7:0]  last_idle,
    output logic [7:0]  last_period,
    output logic        last_oe_low,
    output logic [7:0]  addr_err,
    output logic [7:0]  pair_err
);
    logic [7:0]  mem [256];
    logic [7:0]  wlen, rlen, idle, per, wdat;
    logic [16:0] waddr, raddr;
    logic        oe_seen, ce_prev;

    assign dq = (!ce_n && !oe_n && we_n) ? mem[addr[7:0]] : 8'bz;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        {wlen, rlen, idle, per, wdat} = '0;
        {last_stb, last_rd, last_idle, last_period, addr_err, pair_err} = '0;
        last_oe_low = 1'b0; oe_seen = 1'b0; ce_prev = 1'b1;
        waddr = '0; raddr = '0;
    end

    always @(posedge clk) begin
        ce_prev <= ce_n;
        if (!we_n && ce_n) pair_err <= pair_err + 1;
        if (ce_n === 1'b1) idle <= idle + 1;
        per <= per + 1;
        if (ce_n === 1'b0 && ce_prev === 1'b1) begin
            last_idle <= idle; last_period <= per; idle <= 0; per <= 1;
        end
        if (!ce_n && !we_n) begin
            if (wlen == 0) waddr <= addr;
            else if (addr != waddr) addr_err <= addr_err + 1;
            oe_seen <= (wlen == 0) ? !oe_n : (oe_seen | !oe_n);
            wdat <= dq;
            wlen <= wlen + 1;
        end else if (wlen != 0) begin
            mem[waddr[7:0]] <= wdat;
            last_stb <= wlen; last_oe_low <= oe_seen; wlen <= 0;
        end
        if (!ce_n && !oe_n && we_n) begin
            if (rlen == 0) raddr <= addr;
            else if (addr != raddr) addr_err <= addr_err + 1;
            rlen <= rlen + 1;
        end else if (rlen != 0) begin
            last_rd <= rlen; rlen <= 0;
        end
    end
endmodule

// Bench: instance uut uses the default option, uut_oe holds output-enable
// low during writes. A vector table is walked on each, then directed tests.
module sram_ctl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic        rst_n;
    logic [1:0]  rv, rw;
    logic [16:0] ra [2];
    logic [7:0]  rwd [2];
    wire  [1:0]  rdy, rsv;
    wire  [7:0]  rsd0, rsd1;
    wire  [1:0]  ce_n, oe_n, we_n;
    wire  [16:0] adr0, adr1;
    wire  [7:0]  dq0, dq1;
    wire  [7:0]  stb0, stb1, rdl0, rdl1, idl0, idl1, per0, per1, ae0, ae1, pe0, pe1;
    wire         oel0, oel1;

    int nchk = 0;
    int nfail = 0;

    sram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw[0]),
        .req_addr(ra[0]), .req_wdata(rwd[0]), .req_ready(rdy[0]),
        .rsp_valid(rsv[0]), .rsp_rdata(rsd0), .ram_ce_n(ce_n[0]),
        .ram_oe_n(oe_n[0]), .ram_we_n(we_n[0]), .ram_addr(adr0), .ram_dq(dq0));

    sram_ctl #(.OE_HELD_LOW(1'b1)) uut_oe (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw[1]),
        .req_addr(ra[1]), .req_wdata(rwd[1]), .req_ready(rdy[1]),
        .rsp_valid(rsv[1]), .rsp_rdata(rsd1), .ram_ce_n(ce_n[1]),
        .ram_oe_n(oe_n[1]), .ram_we_n(we_n[1]), .ram_addr(adr1), .ram_dq(dq1));

    sram_ctl_test_ram m0 (.clk(clk), .ce_n(ce_n[0]), .oe_n(oe_n[0]), .we_n(we_n[0]),
        .addr(adr0), .dq(dq0), .last_stb(stb0), .last_rd(rdl0), .last_idle(idl0),
        .last_period(per0), .last_oe_low(oel0), .addr_err(ae0), .pair_err(pe0));
    sram_ctl_test_ram m1 (.clk(clk), .ce_n(ce_n[1]), .oe_n(oe_n[1]), .we_n(we_n[1]),
        .addr(adr1), .dq(dq1), .last_stb(stb1), .last_rd(rdl1), .last_idle(idl1),
        .last_period(per1), .last_oe_low(oel1), .addr_err(ae1), .pair_err(pe1));

    // Vectors: [25] write flag, [24:8] address, [7:0] data (expected for reads).
    localparam int NVEC = 10;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 17'h00000, 8'h5A}, {1'b1, 17'h1FFFF, 8'hA5},
        {1'b1, 17'h0AA55, 8'hFF}, {1'b1, 17'h15501, 8'h00},
        {1'b0, 17'h00000, 8'h5A}, {1'b0, 17'h1FFFF, 8'hA5},
        {1'b0, 17'h0AA55, 8'hFF}, {1'b0, 17'h15501, 8'h00},
        {1'b1, 17'h00000, 8'hC3}, {1'b0, 17'h00000, 8'hC3}};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access on instance k; returns read data and latency in edges.
    task automatic run_op(input int k, input bit w, input logic [16:0] a,
                          input logic [7:0] d, output logic [7:0] got, output int lat);
        @(negedge clk);
        while (!rdy[k]) @(negedge clk);
        rv[k] = 1'b1; rw[k] = w; ra[k] = a; rwd[k] = d;
        @(negedge clk);
        rv[k] = 1'b0;
        got = '0; lat = 0;
        if (!w) begin
            while (!rsv[k] && lat < 50) begin
                @(negedge clk); lat++;
            end
            got = (k == 0) ? rsd0 : rsd1;
            @(negedge clk);
            check(rsv[k] == 1'b0, "R2 pulse", int'(rsv[k]), 0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] got;
        int lat;
        rst_n = 1'b0; rv = '0; rw = '0;
        ra[0] = '0; ra[1] = '0; rwd[0] = '0; rwd[1] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state, both instances
        check(rdy == 2'b11 && rsv == 2'b00, "R1 ready/rsp", {rdy, rsv}, 4'b1100);
        check(ce_n == 2'b11 && oe_n == 2'b11 && we_n == 2'b11, "R1 strobes",
              {ce_n, oe_n, we_n}, 6'h3F);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy == 2'b11 && ce_n == 2'b11 && we_n == 2'b11, "R1 after release",
              {rdy, ce_n, we_n}, 6'h3F);

        for (int k = 0; k < 2; k++) begin
            // Table walk: writes store, reads return the stored byte (R2, R3)
            for (int i = 0; i < NVEC; i++) begin
                run_op(k, VEC[i][25], VEC[i][24:8], VEC[i][7:0], got, lat);
                if (!VEC[i][25]) begin
                    check(got == VEC[i][7:0], "R2/R3 read data", got, VEC[i][7:0]);
                    check(lat == 3, "R2 latency", lat, 3);
                end
            end
            repeat (6) @(negedge clk);
            check(((k == 0) ? rdl0 : rdl1) == 8'd3, "R2 read window",
                  (k == 0) ? rdl0 : rdl1, 3);
            check(((k == 0) ? stb0 : stb1) == ((k == 0) ? 8'd2 : 8'd4),
                  (k == 0) ? "R3 strobe length" : "R5 strobe length",
                  (k == 0) ? stb0 : stb1, (k == 0) ? 2 : 4);
            check(((k == 0) ? oel0 : oel1) == k[0],
                  (k == 0) ? "R4 oe high in write" : "R5 oe low in write",
                  (k == 0) ? oel0 : oel1, k);

            // R6: back-to-back writes
            run_op(k, 1'b1, 17'h00010, 8'h3C, got, lat);
            run_op(k, 1'b1, 17'h00011, 8'hC3, got, lat);
            repeat (6) @(negedge clk);
            check(((k == 0) ? per0 : per1) == ((k == 0) ? 8'd3 : 8'd5), "R6 write period",
                  (k == 0) ? per0 : per1, (k == 0) ? 3 : 5);

            // R7: read followed at once by a write keeps a deselected gap
            run_op(k, 1'b0, 17'h00010, 8'h00, got, lat);
            check(got == 8'h3C, "R7 read before turnaround", got, 8'h3C);
            run_op(k, 1'b1, 17'h00012, 8'h99, got, lat);
            repeat (2) @(negedge clk);
            check(((k == 0) ? idl0 : idl1) >= 8'd2, "R7 idle after read",
                  (k == 0) ? idl0 : idl1, 2);
            run_op(k, 1'b0, 17'h00012, 8'h00, got, lat);
            check(got == 8'h99, "R7 write after read data", got, 8'h99);

            // R8: request while busy is ignored
            run_op(k, 1'b1, 17'h00033, 8'h11, got, lat);
            check(rdy[k] == 1'b0, "R8 ready low when busy", int'(rdy[k]), 0);
            rv[k] = 1'b1; rw[k] = 1'b1; ra[k] = 17'h00033; rwd[k] = 8'hEE;
            @(negedge clk);
            rv[k] = 1'b0;
            run_op(k, 1'b0, 17'h00033, 8'h00, got, lat);
            check(got == 8'h11, "R8 busy request ignored", got, 8'h11);

            // R9 / R3: address stability and strobe pairing seen by the model
            check(((k == 0) ? ae0 : ae1) == 8'd0, "R9 address stable",
                  (k == 0) ? ae0 : ae1, 0);
            check(((k == 0) ? pe0 : pe1) == 8'd0, "R3 strobe pairing",
                  (k == 0) ? pe0 : pe1, 0);
        end
        summary();
    end
endmodule